// File: doc/BRIEF.md
# Indexed Interrupt Redirection Controller

This block routes a fixed set of interrupt input lines to a single message port. Software configures it through two memory-mapped registers. It writes a register number into a selector register and then reads or writes a data window to reach the selected register. Behind the window are an identification register, a version register and a routing table. Each input line owns two 32-bit words in that table: a control word and a destination word.

Each line is sampled every cycle and interpreted according to its configured polarity and trigger mode. Edge-mode lines latch one request per inactive-to-active transition. Level-mode lines request while active, and each one blocks itself after delivery until software writes an end-of-interrupt with the matching vector.

Pending requests from unmasked lines are served lowest line number first. The chosen request becomes a message on a valid/ready port. The message carries the line's vector, destination, destination mode, trigger mode and line number.

Top module: `irq_redirector`

## Requirements
- R1: The selector register is at byte offset 0x00 and reads back what was written into its low 8 bits. The data window is at byte offset 0x10. Any other byte offset reads 0. A selector value that names no register reads 0 through the window, and writes to it change nothing.
- R2: Window register 0x00 holds a writable 8-bit ID in bits 31:24 that resets to the RESET_ID parameter. Window register 0x01 is read-only: it shows N_LINES-1 in bits 23:16 and the VERSION parameter in bits 7:0, and all its other bits are 0.
- R3: Line n's control word is window register 0x10+2n and its destination word is 0x11+2n. In the control word, bit 16 is mask, bit 15 is level mode, bit 14 is the read-only in-service flag, bit 13 is active-low, bit 11 is logical destination mode, and bits 7:0 are the vector. In the destination word, bits 31:24 are the destination. All other bits read 0.
- R4: After reset every control word reads 0x00010000 (masked, edge, active-high, physical, vector 0) and every destination word reads 0.
- R5: An unmasked edge-mode line produces exactly one message for each inactive-to-active transition. Holding the line active produces nothing more.
- R6: With active-low set, a line is active when its input is 0. A high-to-low input transition then counts as the edge, and a low-to-high transition produces no message.
- R7: An edge transition that occurs while the line is masked is dropped and is not delivered after unmasking. A masked level-mode line never sends.
- R8: A level-mode line sets its in-service flag when its message is accepted and sends nothing more while the flag is set. A write to byte offset 0x40 whose bits 7:0 equal the line's vector clears the flag, and a non-matching value has no effect. After the flag clears, the line sends again only if it is still active.
- R9: When several unmasked lines are pending, messages leave in ascending line-number order.
- R10: A message carries the vector, the destination, the logical-mode bit, the level-mode bit and the line number. All of these hold steady while msg_valid is high and msg_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_in | input | N_LINES | Interrupt input lines |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | 8 | Vector of the delivered line |
| msg_dest | output | 8 | Destination identifier |
| msg_logical | output | 1 | Logical destination mode |
| msg_level | output | 1 | Message came from a level-mode line |
| msg_line | output | LW | Number of the delivered line |

## Verification
The bench targets the points a routing controller most often gets wrong. A level line that is not blocked after delivery floods the port with repeated messages. An end-of-interrupt that ignores the vector releases the wrong line. Polarity applied after edge detection, instead of before it, reports the wrong transition. A masked edge that is latched anyway fires as soon as the line is unmasked. Random subsets of simultaneous edges check the order of delivery, and random table writes check that each field lands at its bit position and that the in-service flag cannot be written.

// File: rtl/irq_redirector.sv
module irq_redirector #(
  parameter int N_LINES = 4,
  parameter logic [7:0] RESET_ID = 8'h02,
  parameter logic [7:0] VERSION = 8'h20,
  parameter int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [N_LINES-1:0] irq_in,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [7:0]         msg_vector,
  output logic [7:0]         msg_dest,
  output logic               msg_logical,
  output logic               msg_level,
  output logic [LW-1:0]      msg_line
);
  localparam logic [7:0] MAX_ENTRY = 8'(N_LINES - 1);
  localparam logic [7:0] TBL_BASE = 8'h10;

  logic [7:0] sel_q;
  logic [7:0] id_q;
  logic [N_LINES-1:0] mask_q, level_q, pol_q, logical_q, rirr_q, pend_q, act_q;
  logic [7:0] vec_q [N_LINES];
  logic [7:0] dest_q [N_LINES];

  wire wr      = bus_sel & bus_we;
  wire wr_sel  = wr && bus_addr == 8'h00;
  wire wr_win  = wr && bus_addr == 8'h10;
  wire wr_eoi  = wr && bus_addr == 8'h40;

  wire [N_LINES-1:0] active = irq_in ^ pol_q;
  wire [N_LINES-1:0] rise   = active & ~act_q;

  logic [N_LINES-1:0] req;
  logic [LW-1:0] pick;
  logic any_req;
  logic [31:0] win;

  always_comb begin
    for (int i = 0; i < N_LINES; i++)
      req[i] = ~mask_q[i] & (level_q[i] ? (active[i] & ~rirr_q[i]) : pend_q[i]);
    pick = '0;
    any_req = 1'b0;
    for (int i = N_LINES - 1; i >= 0; i--)
      if (req[i]) begin
        pick = LW'(i);
        any_req = 1'b1;
      end
  end

  wire load = ~msg_valid & any_req;

  always_comb begin
    win = '0;
    if (sel_q == 8'h00) win = {id_q, 24'd0};
    else if (sel_q == 8'h01) win = {8'd0, MAX_ENTRY, 8'd0, VERSION};
    for (int i = 0; i < N_LINES; i++) begin
      if (sel_q == TBL_BASE + 8'(2 * i))
        win = {15'd0, mask_q[i], level_q[i], rirr_q[i], pol_q[i], 1'b0,
               logical_q[i], 3'd0, vec_q[i]};
      if (sel_q == TBL_BASE + 8'(2 * i + 1))
        win = {dest_q[i], 24'd0};
    end
  end

  assign bus_rdata = !bus_sel ? 32'd0 :
                     bus_addr == 8'h00 ? {24'd0, sel_q} :
                     bus_addr == 8'h10 ? win : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q       <= '0;
      id_q        <= RESET_ID;
      mask_q      <= '1;
      level_q     <= '0;
      pol_q       <= '0;
      logical_q   <= '0;
      rirr_q      <= '0;
      pend_q      <= '0;
      act_q       <= '0;
      msg_valid   <= 1'b0;
      msg_vector  <= '0;
      msg_dest    <= '0;
      msg_logical <= 1'b0;
      msg_level   <= 1'b0;
      msg_line    <= '0;
      for (int i = 0; i < N_LINES; i++) begin
        vec_q[i]  <= '0;
        dest_q[i] <= '0;
      end
    end else begin
      if (wr_sel) sel_q <= bus_wdata[7:0];
      if (wr_win && sel_q == 8'h00) id_q <= bus_wdata[31:24];
      act_q <= active;
      for (int i = 0; i < N_LINES; i++) begin
        if (wr_win && sel_q == TBL_BASE + 8'(2 * i)) begin
          mask_q[i]    <= bus_wdata[16];
          level_q[i]   <= bus_wdata[15];
          pol_q[i]     <= bus_wdata[13];
          logical_q[i] <= bus_wdata[11];
          vec_q[i]     <= bus_wdata[7:0];
        end
        if (wr_win && sel_q == TBL_BASE + 8'(2 * i + 1))
          dest_q[i] <= bus_wdata[31:24];
        pend_q[i] <= (pend_q[i] & ~(load && pick == LW'(i)))
                   | (rise[i] & ~mask_q[i] & ~level_q[i]);
        if (wr_eoi && vec_q[i] == bus_wdata[7:0])
          rirr_q[i] <= 1'b0;
      end
      if (load) begin
        msg_valid   <= 1'b1;
        msg_vector  <= vec_q[pick];
        msg_dest    <= dest_q[pick];
        msg_logical <= logical_q[pick];
        msg_level   <= level_q[pick];
        msg_line    <= pick;
      end else if (msg_valid && msg_ready) begin
        msg_valid <= 1'b0;
        if (msg_level) rirr_q[msg_line] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_redirector_chk.sv
module irq_redirector_chk #(
  parameter int N_LINES = 4,
  parameter int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [7:0]         msg_vector,
  input logic [7:0]         msg_dest,
  input logic               msg_logical,
  input logic               msg_level,
  input logic [LW-1:0]      msg_line,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] rirr_q
);
  logic [N_LINES-1:0] mask_d, rirr_d;
  logic [LW-1:0] line_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_d <= '1;
      rirr_d <= '0;
      line_d <= '0;
    end else begin
      mask_d <= mask_q;
      rirr_d <= rirr_q;
      line_d <= msg_line;
    end
  end

  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest)
      && $stable(msg_logical) && $stable(msg_level) && $stable(msg_line));

  // R7
  masked_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> !mask_d[msg_line]);

  // R8
  rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && msg_level |=> rirr_q[line_d]);

  // R8
  level_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) && msg_level |-> !rirr_d[msg_line]);
endmodule

bind irq_redirector irq_redirector_chk #(.N_LINES(N_LINES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_logical(msg_logical),
  .msg_level(msg_level), .msg_line(msg_line), .mask_q(mask_q), .rirr_q(rirr_q));

// File: tb/tb_irq_redirector.sv
`timescale 1ns/1ps
module tb_irq_redirector;
  localparam int N = 4;
  localparam logic [7:0] RID = 8'h02;
  localparam logic [7:0] VER = 8'h20;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [N-1:0] irq_in = 0;
  logic msg_valid, msg_ready = 0;
  logic [7:0] msg_vector, msg_dest;
  logic msg_logical, msg_level;
  logic [1:0] msg_line;

  int checks = 0, fails = 0;

  irq_redirector #(.N_LINES(N), .RESET_ID(RID), .VERSION(VER)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] low_expect(input logic [31:0] d);
    return d & 32'h0001_A8FF;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
    bus_write(8'h00, {24'd0, idx});
    bus_write(8'h10, d);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
    bus_write(8'h00, {24'd0, idx});
    bus_read(8'h10, d);
  endtask

  task automatic take_msg(output bit got, output logic [7:0] vec, output logic [7:0] dst,
                          output logic lg, output logic lv, output logic [1:0] ln);
    got = 0; vec = 0; dst = 0; lg = 0; lv = 0; ln = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (msg_valid) begin
        vec = msg_vector; dst = msg_dest; lg = msg_logical; lv = msg_level; ln = msg_line;
        msg_ready = 1;
        @(negedge clk);
        msg_ready = 0;
        got = 1;
        break;
      end
    end
  endtask

  task automatic quiet(input int n, input string tag);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (msg_valid) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  task automatic park_all();
    for (int i = 0; i < N; i++) begin
      reg_write(8'(16 + 2 * i), 32'h0001_0000);
      reg_write(8'(17 + 2 * i), 32'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r, d, h;
    bit got;
    logic [7:0] v, ds;
    logic lg, lv;
    logic [1:0] ln;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R4 / R2 reset state
    reg_read(8'h00, r); check(r == {RID, 24'd0}, "R2 id reset", r, {RID, 24'd0});
    reg_read(8'h01, r); check(r == {8'd0, 8'(N - 1), 8'd0, VER}, "R2 version", r, {8'd0, 8'(N - 1), 8'd0, VER});
    for (int i = 0; i < N; i++) begin
      reg_read(8'(16 + 2 * i), r); check(r == 32'h0001_0000, "R4 low reset", r, 32'h0001_0000);
      reg_read(8'(17 + 2 * i), r); check(r == 0, "R4 high reset", r, 0);
    end

    // R1 selector and unimplemented indices
    bus_write(8'h00, 32'hFFFF_FF37); bus_read(8'h00, r); check(r == 32'h37, "R1 selector", r, 32'h37);
    reg_write(8'h05, 32'hDEAD_BEEF); reg_read(8'h05, r); check(r == 0, "R1 hole", r, 0);
    reg_write(8'(16 + 2 * N), 32'h1234_5678); reg_read(8'(16 + 2 * N), r); check(r == 0, "R1 past table", r, 0);
    bus_read(8'h20, r); check(r == 0, "R1 other offset", r, 0);

    // R2 id write, version read-only
    reg_write(8'h00, 32'hA5FF_FFFF); reg_read(8'h00, r); check(r == 32'hA500_0000, "R2 id write", r, 32'hA500_0000);
    reg_write(8'h01, 32'hFFFF_FFFF); reg_read(8'h01, r); check(r == {8'd0, 8'(N - 1), 8'd0, VER}, "R2 version ro", r, {8'd0, 8'(N - 1), 8'd0, VER});

    // R3 random field placement (lines kept masked)
    for (int t = 0; t < 20; t++) begin
      int ln_r = $urandom_range(N - 1);
      d = $urandom() | 32'h0001_0000;
      h = $urandom();
      reg_write(8'(16 + 2 * ln_r), d);
      reg_write(8'(17 + 2 * ln_r), h);
      reg_read(8'(16 + 2 * ln_r), r); check(r == low_expect(d), "R3 low fields", r, low_expect(d));
      reg_read(8'(17 + 2 * ln_r), r); check(r == (h & 32'hFF00_0000), "R3 high field", r, h & 32'hFF00_0000);
    end
    park_all();

    // R5 edge mode
    reg_write(8'h13, 32'h0700_0000);
    reg_write(8'h12, 32'h0000_0041);
    @(negedge clk) irq_in[1] = 1;
    take_msg(got, v, ds, lg, lv, ln);
    check(got && v == 8'h41 && ds == 8'h07 && ln == 1 && !lv, "R5 edge msg", {got, ln, ds, v}, {1'b1, 2'd1, 8'h07, 8'h41});
    quiet(12, "R5 held level no resend");
    @(negedge clk) irq_in[1] = 0;
    @(negedge clk) irq_in[1] = 1;
    take_msg(got, v, ds, lg, lv, ln);
    check(got && v == 8'h41, "R5 second edge", {got, v}, {1'b1, 8'h41});
    @(negedge clk) irq_in[1] = 0;
    reg_write(8'h12, 32'h0001_0041);

    // R10 hold under backpressure, logical bit
    reg_write(8'h15, 32'h3300_0000);
    reg_write(8'h14, 32'h0000_0852);
    @(negedge clk) irq_in[2] = 1;
    for (int k = 0; k < 10 && !msg_valid; k++) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(msg_valid && msg_vector == 8'h52 && msg_dest == 8'h33 && msg_logical && msg_line == 2,
            "R10 held message", {msg_valid, msg_line, msg_dest, msg_vector}, {1'b1, 2'd2, 8'h33, 8'h52});
    end
    take_msg(got, v, ds, lg, lv, ln);
    check(got && lg && v == 8'h52, "R10 accepted", {got, lg, v}, {1'b1, 1'b1, 8'h52});
    @(negedge clk) irq_in[2] = 0;
    reg_write(8'h14, 32'h0001_0852);

    // R6 active-low
    @(negedge clk) irq_in[3] = 1;
    reg_write(8'h16, 32'h0000_2063);
    quiet(8, "R6 idle high no msg");
    @(negedge clk) irq_in[3] = 0;
    take_msg(got, v, ds, lg, lv, ln);
    check(got && v == 8'h63 && ln == 3, "R6 falling edge", {got, ln, v}, {1'b1, 2'd3, 8'h63});
    @(negedge clk) irq_in[3] = 1;
    quiet(8, "R6 rising no msg");
    reg_write(8'h16, 32'h0001_2063);
    @(negedge clk) irq_in[3] = 0;

    // R7 masked edge dropped, masked level silent
    reg_write(8'h10, 32'h0001_0044);
    @(negedge clk) irq_in[0] = 1;
    @(negedge clk) irq_in[0] = 0;
    reg_write(8'h10, 32'h0000_0044);
    quiet(10, "R7 masked edge dropped");
    reg_write(8'h10, 32'h0001_8060);
    @(negedge clk) irq_in[0] = 1;
    quiet(10, "R7 masked level silent");

    // R8 level and end-of-interrupt
    reg_write(8'h10, 32'h0000_8060);
    take_msg(got, v, ds, lg, lv, ln);
    check(got && lv && v == 8'h60, "R8 level msg", {got, lv, v}, {1'b1, 1'b1, 8'h60});
    reg_read(8'h10, r); check(r[14], "R8 in-service set", r, 32'h0000_C060);
    quiet(10, "R8 blocked while in service");
    bus_write(8'h40, 32'h61);
    quiet(10, "R8 non-matching eoi");
    reg_read(8'h10, r); check(r[14], "R8 flag kept", r, 32'h0000_C060);
    bus_write(8'h40, 32'h60);
    take_msg(got, v, ds, lg, lv, ln);
    check(got && v == 8'h60, "R8 resend still active", {got, v}, {1'b1, 8'h60});
    @(negedge clk) irq_in[0] = 0;
    bus_write(8'h40, 32'h60);
    quiet(10, "R8 no resend when inactive");
    reg_read(8'h10, r); check(r == 32'h0000_8060, "R8 flag cleared", r, 32'h0000_8060);
    park_all();

    // R9 random simultaneous edges
    for (int i = 0; i < N; i++) reg_write(8'(16 + 2 * i), 32'(8'h70 + i));
    for (int t = 0; t < 12; t++) begin
      logic [N-1:0] s;
      s = N'($urandom_range((1 << N) - 1, 1));
      @(negedge clk) irq_in = s;
      for (int i = 0; i < N; i++) begin
        if (s[i]) begin
          take_msg(got, v, ds, lg, lv, ln);
          check(got && ln == 2'(i) && v == 8'(8'h70 + i), "R9 order", {got, ln}, {1'b1, 2'(i)});
        end
      end
      quiet(4, "R9 no extra");
      @(negedge clk) irq_in = 0;
      repeat (2) @(negedge clk);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule